// File: doc/BRIEF.md
# Serial Control Register Port

This block receives configuration for an audio gain and deemphasis path over a three-wire, write-only serial link. The link has a data line, a shift clock and a latch line. All three lines are oversampled by the block's system clock. Each rising edge of the shift clock pushes one data bit into a 12-bit shift window. A rising edge of the latch line commits the window. The first bit of the frame picks its destination: either an 11-bit gain word or a packed set of mode flags. The flags are the ratio-tracking mode, the +12 dB boost, the two deemphasis rate-select bits and the deemphasis enable.

A mode input chooses the source of the configuration. In host mode the block outputs the serially written registers. In pin mode the deemphasis enable and rate select come straight from dedicated pins, and the gain is held at unity. The rate select is always presented as a decoded three-way code. A one-cycle pulse marks every change of that code, in either mode.

Top module: `ctrl_serial_port`

## Requirements
- R1: The data line is captured on each rising edge of the shift clock. Only the last 12 captured bits form the frame, so any earlier bits are discarded.
- R2: On a latch rising edge with first bit D1 = 0, bits D2..D12 load the gain word as an 11-bit unsigned value, with D2 as the most significant bit.
- R3: On a latch rising edge with D1 = 1, the flags load as follows: D8 sets the ratio-tracking mode, D9 the +12 dB boost, D10 rate-select bit 1, D11 rate-select bit 2 and D12 the deemphasis enable. Bits D2..D7 are ignored, and the gain word is unchanged.
- R4: A gain frame (D1 = 0) leaves every flag unchanged.
- R5: The rate code output is decoded from the effective select bits (bit 1, bit 2). 0,0 gives code 0 (44.1 kHz). 1,1 gives code 2 (32 kHz). Either mixed pair gives code 1 (48 kHz). Code 3 never appears.
- R6: Reset sets the gain word to 0x400 and clears all flags.
- R7: With the mode input low, the gain output is 0x400 and boost and ratio-tracking are 0. The deemphasis enable follows its pin, and the rate select follows pinRateSel[0] (bit 1) and pinRateSel[1] (bit 2). The serially written registers keep their contents for a later return to host mode.
- R8: rateChg goes high for one cycle, one clock after the decoded rate code takes a new value, in either mode. The reference value after reset is code 0.
- R9: Shifting bits without a latch edge changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostMode | input | 1 | 1: serial registers in effect, 0: direct pins in effect |
| serData | input | 1 | Serial data line |
| serClk | input | 1 | Serial shift clock |
| latchEn | input | 1 | Latch line, commits on rising edge |
| pinDeemOn | input | 1 | Deemphasis enable in pin mode |
| pinRateSel | input | 2 | Rate-select bits in pin mode ([0] = bit 1, [1] = bit 2) |
| gainCode | output | 11 | Effective gain word |
| fineRateMode | output | 1 | Ratio-tracking mode flag (1 = precise update every 2048 samples) |
| gainBoost | output | 1 | +12 dB boost flag |
| deemOn | output | 1 | Effective deemphasis enable |
| deemFreq | output | 2 | Decoded deemphasis rate code (0: 44.1, 1: 48, 2: 32 kHz) |
| rateChg | output | 1 | One-cycle pulse on a change of deemFreq |

## Verification
The stimulus table sends gain frames at the extremes and in the middle of the 11-bit range, and flag frames that set one field at a time. Together these tell the bit position of each field apart from its neighbours. One flag frame sets every test bit to show they are ignored. Others alternate between the two frame types to show each type leaves the other register alone. Directed tests send a frame led by surplus bits, shift without latching, and step the rate pins through a mixed pair and its mirror, which must give no pulse. They also leave and re-enter host mode, and reset in the middle of a frame.

// File: rtl/ctrl_serial_pkg.sv
package ctrl_serial_pkg;
  localparam int FRAME_W = 12;
  localparam int GAIN_W  = FRAME_W - 1;
  localparam int FLAG_W  = 5;
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1) << (GAIN_W - 1);

  typedef enum logic [1:0] {
    FS_44K1 = 2'd0,
    FS_48K  = 2'd1,
    FS_32K  = 2'd2
  } deemFreq_e;

  typedef struct packed {
    logic fine;
    logic boost;
    logic sel1;
    logic sel2;
    logic deem;
  } flags_t;

  typedef struct packed {
    logic shiftStb;
    logic latchStb;
    logic bitIn;
  } ctlStrobes_t;

  function automatic deemFreq_e rateDecode(input logic sel1, input logic sel2);
    if (!sel1 && !sel2)     return FS_44K1;
    else if (sel1 && sel2)  return FS_32K;
    else                    return FS_48K;
  endfunction
endpackage

// File: rtl/ctrl_serial_ctl.sv
module ctrl_serial_ctl
  import ctrl_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        serData,
  input  logic        serClk,
  input  logic        latchEn,
  output ctlStrobes_t stb
);
  localparam int EDGE_W = SYNC_STAGES + 1;

  logic [EDGE_W-1:0]      clkPipe;
  logic [EDGE_W-1:0]      lePipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  // Data pipe is one stage shorter so its tap lines up with the edge tap.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkPipe  <= '0;
      lePipe   <= '0;
      dataPipe <= '0;
    end else begin
      clkPipe  <= {clkPipe[EDGE_W-2:0], serClk};
      lePipe   <= {lePipe[EDGE_W-2:0], latchEn};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], serData};
    end
  end

  always_comb begin
    stb.shiftStb = clkPipe[SYNC_STAGES-1] & ~clkPipe[SYNC_STAGES];
    stb.latchStb = lePipe[SYNC_STAGES-1] & ~lePipe[SYNC_STAGES];
    stb.bitIn    = dataPipe[SYNC_STAGES-1];
  end

  // R1: one shift per clock edge, never two strobes back to back
  p_shift_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftStb |=> !stb.shiftStb);

  // R9: one commit per latch edge
  p_latch_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.latchStb |=> !stb.latchStb);
endmodule

// File: rtl/ctrl_serial_dp.sv
module ctrl_serial_dp
  import ctrl_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       stb,
  input  logic              hostMode,
  input  logic              pinDeemOn,
  input  logic [1:0]        pinRateSel,
  output logic [GAIN_W-1:0] gainCode,
  output logic              fineRateMode,
  output logic              gainBoost,
  output logic              deemOn,
  output logic [1:0]        deemFreq,
  output logic              rateChg
);
  logic [FRAME_W-1:0] shiftWin;
  logic [GAIN_W-1:0]  gainReg;
  flags_t             flagReg;
  flags_t             frameFlags;
  logic               frameIsFlag;
  deemFreq_e          curFreq;
  deemFreq_e          prevFreq;
  logic               effSel1;
  logic               effSel2;

  // Frame bit D1 sits at the top once twelve bits are in; D12 at bit 0.
  assign frameIsFlag      = shiftWin[FRAME_W-1];
  assign frameFlags.fine  = shiftWin[4];
  assign frameFlags.boost = shiftWin[3];
  assign frameFlags.sel1  = shiftWin[2];
  assign frameFlags.sel2  = shiftWin[1];
  assign frameFlags.deem  = shiftWin[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftWin <= '0;
      gainReg  <= GAIN_UNITY;
      flagReg  <= '0;
    end else begin
      if (stb.shiftStb) shiftWin <= {shiftWin[FRAME_W-2:0], stb.bitIn};
      if (stb.latchStb) begin
        if (frameIsFlag) flagReg <= frameFlags;
        else             gainReg <= shiftWin[GAIN_W-1:0];
      end
    end
  end

  always_comb begin
    effSel1      = hostMode ? flagReg.sel1 : pinRateSel[0];
    effSel2      = hostMode ? flagReg.sel2 : pinRateSel[1];
    curFreq      = rateDecode(effSel1, effSel2);
    deemFreq     = curFreq;
    deemOn       = hostMode ? flagReg.deem : pinDeemOn;
    gainCode     = hostMode ? gainReg : GAIN_UNITY;
    gainBoost    = hostMode & flagReg.boost;
    fineRateMode = hostMode & flagReg.fine;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevFreq <= FS_44K1;
      rateChg  <= 1'b0;
    end else begin
      prevFreq <= curFreq;
      rateChg  <= (curFreq != prevFreq);
    end
  end

  // R3: a flag frame must not disturb the gain word
  p_flag_keeps_gain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchStb && frameIsFlag) |=> $stable(gainReg));

  // R4: a gain frame must not disturb the flags
  p_gain_keeps_flags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.latchStb && !frameIsFlag) |=> $stable(flagReg));

  // R9: registers move only on a latch commit
  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.latchStb |=> ($stable(gainReg) && $stable(flagReg)));

  // R5: the decoded rate code stays within its three legal values
  p_freq_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    deemFreq != 2'd3);
endmodule

// File: rtl/ctrl_serial_port.sv
module ctrl_serial_port
  import ctrl_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostMode,
  input  logic              serData,
  input  logic              serClk,
  input  logic              latchEn,
  input  logic              pinDeemOn,
  input  logic [1:0]        pinRateSel,
  output logic [GAIN_W-1:0] gainCode,
  output logic              fineRateMode,
  output logic              gainBoost,
  output logic              deemOn,
  output logic [1:0]        deemFreq,
  output logic              rateChg
);
  ctlStrobes_t stb;

  ctrl_serial_ctl #(.SYNC_STAGES(SYNC_STAGES)) i_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .serData (serData),
    .serClk  (serClk),
    .latchEn (latchEn),
    .stb     (stb)
  );

  ctrl_serial_dp i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .hostMode     (hostMode),
    .pinDeemOn    (pinDeemOn),
    .pinRateSel   (pinRateSel),
    .gainCode     (gainCode),
    .fineRateMode (fineRateMode),
    .gainBoost    (gainBoost),
    .deemOn       (deemOn),
    .deemFreq     (deemFreq),
    .rateChg      (rateChg)
  );
endmodule

// File: tb/test_ctrl_serial_port.sv
module test_ctrl_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 9;

  // entry: {frame[11:0], gain[10:0], fine, boost, freq[1:0], deem}
  localparam logic [27:0] VEC [N_VEC] = '{
    {12'h001, 11'h001, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 smallest nonzero gain
    {12'h3FF, 11'h3FF, 1'b0, 1'b0, 2'd0, 1'b0}, // R2
    {12'h7FF, 11'h7FF, 1'b0, 1'b0, 2'd0, 1'b0}, // R2 all gain bits
    {12'h810, 11'h7FF, 1'b1, 1'b0, 2'd0, 1'b0}, // R3 D8 only, gain kept
    {12'h80D, 11'h7FF, 1'b0, 1'b1, 2'd1, 1'b1}, // R3 D9 D10 D12, sel 1,0 -> 48
    {12'hFE3, 11'h7FF, 1'b0, 1'b0, 2'd1, 1'b1}, // R3 test bits ignored, sel 0,1 -> 48
    {12'h806, 11'h7FF, 1'b0, 1'b0, 2'd2, 1'b0}, // R5 sel 1,1 -> 32
    {12'h400, 11'h400, 1'b0, 1'b0, 2'd2, 1'b0}, // R4 flags kept
    {12'h000, 11'h000, 1'b0, 1'b0, 2'd2, 1'b0}  // R2 zero gain
  };

  logic clk = 1'b0;
  logic rstN, hostMode, serData, serClk, latchEn, pinDeemOn;
  logic [1:0] pinRateSel;
  logic [10:0] gainCode;
  logic fineRateMode, gainBoost, deemOn, rateChg;
  logic [1:0] deemFreq;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && rateChg) pulses++;

  ctrl_serial_port i_ctrl_serial_port (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .serData(serData),
    .serClk(serClk), .latchEn(latchEn), .pinDeemOn(pinDeemOn),
    .pinRateSel(pinRateSel), .gainCode(gainCode), .fineRateMode(fineRateMode),
    .gainBoost(gainBoost), .deemOn(deemOn), .deemFreq(deemFreq), .rateChg(rateChg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      waitClk(3);
      serClk = 1'b1;
      waitClk(3);
      serClk = 1'b0;
    end
  endtask

  task automatic pulseLatch();
    waitClk(2);
    latchEn = 1'b1;
    waitClk(3);
    latchEn = 1'b0;
    waitClk(6);
  endtask

  function automatic logic [15:0] outWord();
    return {gainCode, fineRateMode, gainBoost, deemFreq, deemOn};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; hostMode = 1'b1; serData = 1'b0; serClk = 1'b0;
    latchEn = 1'b0; pinDeemOn = 1'b0; pinRateSel = 2'b00;
    waitClk(4);
    rstN = 1'b1;
    waitClk(4);
    chk("R6 reset gain", 32'(gainCode), 32'h400);
    chk("R6 reset flags", 32'({fineRateMode, gainBoost, deemFreq, deemOn}), 32'h0);

    for (int v = 0; v < N_VEC; v++) begin
      sendBits(16'(VEC[v][27:16]), 12);
      pulseLatch();
      chk($sformatf("R2/R3/R4/R5 vector %0d", v), 32'(outWord()), 32'(VEC[v][15:0]));
    end
    chk("R8 pulses after table", 32'(pulses), 32'd2);

    // R1: surplus leading bits are pushed out of the window
    sendBits(16'hA123, 16);
    pulseLatch();
    chk("R1 last twelve bits", 32'(gainCode), 32'h123);

    // R9: shifting without a latch changes nothing
    sendBits(16'h0055, 12);
    waitClk(10);
    chk("R9 no latch gain", 32'(gainCode), 32'h123);
    chk("R9 no latch flags", 32'({fineRateMode, gainBoost, deemFreq, deemOn}), 32'h4);

    // R7: pin mode
    pinRateSel = 2'b11; pinDeemOn = 1'b1;
    hostMode = 1'b0;
    waitClk(4);
    chk("R7 pin gain unity", 32'(gainCode), 32'h400);
    chk("R7 pin flags", 32'({fineRateMode, gainBoost, deemFreq, deemOn}), 32'h5);
    chk("R8 no pulse equal code", 32'(pulses), 32'd2);
    pinRateSel = 2'b01;
    waitClk(4);
    chk("R5 pin sel 1,0", 32'(deemFreq), 32'd1);
    chk("R8 pin change pulse", 32'(pulses), 32'd3);
    pinRateSel = 2'b10;
    waitClk(4);
    chk("R5 pin sel 0,1", 32'(deemFreq), 32'd1);
    chk("R8 mirror pair no pulse", 32'(pulses), 32'd3);

    // R7: frames written in pin mode are stored, not applied
    sendBits(16'h0200, 12);
    pulseLatch();
    chk("R7 pin gain still unity", 32'(gainCode), 32'h400);
    hostMode = 1'b1;
    waitClk(4);
    chk("R7 host gain restored", 32'(gainCode), 32'h200);
    chk("R7 host flags restored", 32'({fineRateMode, gainBoost, deemFreq, deemOn}), 32'h4);
    chk("R8 pulse on mode return", 32'(pulses), 32'd4);

    // R6: reset in the middle of a frame
    sendBits(16'h0812, 6);
    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    serClk = 1'b0;
    waitClk(4);
    chk("R6 mid-frame reset gain", 32'(gainCode), 32'h400);
    chk("R6 mid-frame reset flags", 32'({fineRateMode, gainBoost, deemFreq, deemOn}), 32'h0);
    sendBits(16'h0801, 12);
    pulseLatch();
    chk("R3 deem only after reset", 32'(outWord()), 32'({11'h400, 5'b00001}));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule